// File: doc/BRIEF.md
# Dual-IO Serial Flash Read Engine

This block is the host side of a serial flash read path built on the dual-I/O fast read command. A client gives a start address, a byte count and a flag asking for continuous operation. The engine lowers chip select and sends the command byte on one line. It then sends the address and a mode byte on both lines, releases the lines and returns the data bytes one at a time, each with a single-cycle valid strobe.

The engine keeps one state bit that records whether the flash was left in continuous mode. While that bit is set, the next read starts straight at the address and omits the command byte. A separate exit request drives sixteen clocks of ones on IO0, which returns the flash to normal command decoding and clears the state bit.

Each serial clock period takes two system clock cycles. The serial clock idle level comes from a configuration input, so the engine works with flash in either mode 0 or mode 3.

Top module: `dio_flash_rd`

## Requirements
- R1: When not in continuous state, a read begins with the command byte BBh on IO0, MSB first, one bit per serial clock over 8 clocks, with io_oe = 01.
- R2: The 24-bit address follows on both lines over 12 clocks. Each clock carries two bits, with the higher bit on IO1, so the first clock carries A23 on IO1 and A22 on IO0.
- R3: After the address, a mode byte goes out over 4 clocks with M7 on IO1 in the first clock. It is A0h when the continuous flag was set with the request, and 00h otherwise.
- R4: A read that sent mode A0h puts the engine into continuous state. The next read then has no command byte and starts with the address clocks. A read sent with 00h clears the state. Reset clears the state.
- R5: From the first data clock until chip select rises, io_oe is 00. It drops together with the falling serial clock edge that starts the data phase.
- R6: Data is sampled while the serial clock is high, two bits per clock with the higher bit on IO1, and the first clock carries bits 7:6. After every fourth clock, rd_valid_o pulses for one cycle with the byte. Exactly len_i bytes are returned, and a length of 0 is read as 1.
- R7: exit_i accepted while idle runs 16 clocks with IO0 driven high and IO1 released, then clears the continuous state. exit_i takes priority over req_i in the same cycle.
- R8: While chip select is high, sck_o equals cpol_i. While chip select is low, sck_o toggles every system cycle, starting low.
- R9: Chip select stays high for at least two system cycles between transactions. busy_o is high from acceptance until that gap ends, and requests made while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cpol_i | input | 1 | Serial clock idle level (0 = mode 0, 1 = mode 3) |
| req_i | input | 1 | Start a read (taken when idle) |
| addr_i | input | ADDR_W | Start address |
| len_i | input | LEN_W | Number of bytes to read (0 reads one) |
| cont_i | input | 1 | Leave the flash in continuous mode after this read |
| exit_i | input | 1 | Run the continuous-mode exit sequence |
| busy_o | output | 1 | Transaction or inter-transaction gap in progress |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_data_o holds a new byte |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock |
| io_o | output | 2 | Values driven on IO1/IO0 |
| io_oe_o | output | 2 | Output enables for IO1/IO0 |
| io_i | input | 2 | Values sampled from IO1/IO0 |

## Verification
The hardest situation to reach is the engine and the flash agreeing, or failing to agree, on whether the command byte is present. That state is never visible at the ports; it only shows up as a shift of every later field. The bench models the flash from the line activity alone. The model tracks its own continuous state from the mode bits it receives and from a recognised sixteen-clock exit. The stimulus chains continuous reads, a zero-length read that clears the state, an exit, and an exit raised together with a read, in both clock polarities. Any disagreement shows up as a wrong address, a wrong clock count or wrong data.

// File: rtl/dio_flash_rd.sv
module dio_flash_rd #(
  parameter int ADDR_W = 24,
  parameter int LEN_W = 16,
  parameter logic [7:0] CMD = 8'hBB,
  parameter logic [7:0] MODE_CONT = 8'hA0,
  parameter logic [7:0] MODE_NORM = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              cont_i,
  input  logic              exit_i,
  output logic              busy_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic [1:0]        io_o,
  output logic [1:0]        io_oe_o,
  input  logic [1:0]        io_i
);
  localparam int SW = ADDR_W + 8;
  localparam int AC = ADDR_W / 2;
  localparam int BC_MAX = (AC > 16) ? AC : 16;
  localparam int BW = $clog2(BC_MAX);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_MODE, S_DATA, S_EXIT, S_GAP} st_t;

  st_t             st;
  logic            ph;
  logic [BW-1:0]   bc;
  logic [SW-1:0]   osr;
  logic [LEN_W-1:0] cnt;
  logic [5:0]      sh;
  logic            cont_r, creq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= 1'b0;
      bc <= '0;
      osr <= '0;
      cnt <= '0;
      sh <= '0;
      cont_r <= 1'b0;
      creq <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      case (st)
        S_IDLE: begin
          ph <= 1'b0;
          if (exit_i) begin
            st <= S_EXIT;
            bc <= BW'(15);
          end else if (req_i) begin
            creq <= cont_i;
            osr <= {addr_i, cont_i ? MODE_CONT : MODE_NORM};
            cnt <= (len_i == '0) ? '0 : len_i - 1'b1;
            if (cont_r) begin
              st <= S_ADDR;
              bc <= BW'(AC - 1);
            end else begin
              st <= S_CMD;
              bc <= BW'(7);
            end
          end
        end
        S_GAP: begin
          ph <= ~ph;
          if (ph) begin
            if (bc == '0) st <= S_IDLE;
            else bc <= bc - 1'b1;
          end
        end
        default: begin
          ph <= ~ph;
          if (ph) begin
            if (st == S_DATA) sh <= {sh[3:0], io_i};
            if (st == S_ADDR || st == S_MODE) osr <= osr << 2;
            if (bc != '0) begin
              bc <= bc - 1'b1;
            end else begin
              case (st)
                S_CMD: begin
                  st <= S_ADDR;
                  bc <= BW'(AC - 1);
                end
                S_ADDR: begin
                  st <= S_MODE;
                  bc <= BW'(3);
                end
                S_MODE: begin
                  st <= S_DATA;
                  bc <= BW'(3);
                  cont_r <= creq;
                end
                S_DATA: begin
                  rd_valid_o <= 1'b1;
                  rd_data_o <= {sh, io_i};
                  if (cnt == '0) begin
                    st <= S_GAP;
                    bc <= '0;
                  end else begin
                    cnt <= cnt - 1'b1;
                    bc <= BW'(3);
                  end
                end
                S_EXIT: begin
                  st <= S_GAP;
                  bc <= '0;
                  cont_r <= 1'b0;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign cs_n_o = (st == S_IDLE) || (st == S_GAP);
  assign sck_o  = cs_n_o ? cpol_i : ph;
  assign busy_o = (st != S_IDLE);

  always_comb begin
    case (st)
      S_CMD:          begin io_o = {1'b0, CMD[bc[2:0]]}; io_oe_o = 2'b01; end
      S_ADDR, S_MODE: begin io_o = osr[SW-1 -: 2];       io_oe_o = 2'b11; end
      S_EXIT:         begin io_o = 2'b01;                io_oe_o = 2'b01; end
      default:        begin io_o = 2'b00;                io_oe_o = 2'b00; end
    endcase
  end
endmodule

// File: rtl/dio_flash_rd_chk.sv
module dio_flash_rd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpol_i,
  input logic       cs_n_o,
  input logic       sck_o,
  input logic [1:0] io_oe_o,
  input logic       rd_valid_o,
  input logic       busy_o
);
  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sck_o == cpol_i);

  // R8
  sck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !$past(cs_n_o)) |-> sck_o != $past(sck_o));

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> cs_n_o);

  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  // R5
  io_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && io_oe_o == 2'b00) |=> (cs_n_o || io_oe_o == 2'b00));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind dio_flash_rd dio_flash_rd_chk u_chk (.*);

// File: tb/sim_dio_flash_rd.sv
module sim_dio_flash_rd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0;
  logic req = 1'b0, cont = 1'b0, ext = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] len = '0;
  logic busy, rd_valid, cs_n, sck;
  logic [7:0] rd_data;
  logic [1:0] io_o, io_oe;
  logic [1:0] fio = 2'b00;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dio_flash_rd u0 (
    .clk(clk), .rst_n(rst_n), .cpol_i(cpol), .req_i(req), .addr_i(addr),
    .len_i(len), .cont_i(cont), .exit_i(ext), .busy_o(busy),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .cs_n_o(cs_n), .sck_o(sck),
    .io_o(io_o), .io_oe_o(io_oe), .io_i(fio)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5C;
  endfunction

  logic [7:0] q[$];
  int ntx = 0, exp_ntx = 0;
  bit bench_cont = 0;
  bit exp_exit, exp_cmd;
  logic [23:0] exp_addr;
  logic [7:0] exp_mode;
  int exp_edges;

  // flash model
  bit fl_cont = 0;
  int edges = 0;
  bit exit_ok = 1;
  int dpos = 0;
  logic [7:0] rx_cmd, rx_mode;
  logic [23:0] rx_addr;
  realtime t_rise = 0;

  always @(posedge sck) if (!cs_n) begin
    if (!fl_cont && edges < 8) rx_cmd = {rx_cmd[6:0], io_o[0]};
    else begin
      int k;
      k = edges - (fl_cont ? 0 : 8);
      if (k < 12) rx_addr = {rx_addr[21:0], io_o};
      else if (k < 16) rx_mode = {rx_mode[5:0], io_o};
    end
    if (!(io_oe[0] && io_o[0] && !io_oe[1])) exit_ok = 0;
    edges++;
  end

  always @(negedge sck) if (!cs_n && edges >= (fl_cont ? 16 : 24)) begin
    logic [7:0] b;
    b = pat(rx_addr + 24'(dpos / 4));
    fio = b[7 - 2*(dpos % 4) -: 2];
    dpos++;
    #1;
    // R5
    chk(io_oe == 2'b00, "R5", "io_oe in data phase", io_oe, 0);
  end

  always @(negedge cs_n) begin
    // R9
    chk(($realtime - t_rise) >= 8.0, "R9", "cs high gap ns", int'($realtime - t_rise), 8);
  end

  always @(posedge cs_n) if (rst_n) begin
    t_rise = $realtime;
    ntx++;
    if (exp_exit) begin
      // R7
      chk(edges == 16 && exit_ok, "R7", "exit clocks with IO0 high", edges, 16);
      if (fl_cont && edges == 16 && exit_ok) fl_cont = 0;
    end else begin
      if (exp_cmd)
        // R1
        chk(!fl_cont && rx_cmd == 8'hBB, "R1", "command byte", rx_cmd, 8'hBB);
      else
        // R4
        chk(fl_cont, "R4", "command omitted in continuous state", fl_cont, 1);
      // R2
      chk(rx_addr == exp_addr, "R2", "address", rx_addr, exp_addr);
      // R3
      chk(rx_mode == exp_mode, "R3", "mode byte", rx_mode, exp_mode);
      // R6
      chk(edges == exp_edges, "R6", "clock count", edges, exp_edges);
      if (edges >= (fl_cont ? 16 : 24)) fl_cont = (rx_mode[5:4] == 2'b10);
    end
    edges = 0; dpos = 0; exit_ok = 1;
    rx_cmd = '0; rx_addr = '0; rx_mode = '0;
  end

  // scoreboard monitor
  always @(negedge clk) if (rd_valid) begin
    if (q.size() == 0) chk(0, "R6", "unexpected byte", rd_data, 0);
    else begin
      logic [7:0] e;
      e = q.pop_front();
      // R6
      chk(rd_data == e, "R6", "read byte", rd_data, e);
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input logic [23:0] a, input logic [15:0] n, input bit c);
    int cnt;
    wait_idle();
    // R8
    chk(sck == cpol, "R8", "idle clock level", sck, cpol);
    cnt = (n == 0) ? 1 : n;
    exp_exit = 0; exp_cmd = !bench_cont; exp_addr = a;
    exp_mode = c ? 8'hA0 : 8'h00;
    exp_edges = (bench_cont ? 16 : 24) + 4 * cnt;
    for (int i = 0; i < cnt; i++) q.push_back(pat(a + 24'(i)));
    addr = a; len = n; cont = c; req = 1;
    @(negedge clk);
    req = 0;
    bench_cont = c;
    exp_ntx++;
  endtask

  task automatic do_exit(input bit with_req);
    wait_idle();
    exp_exit = 1;
    ext = 1; req = with_req; addr = 24'h111111; len = 16'd2; cont = 0;
    @(negedge clk);
    ext = 0; req = 0;
    bench_cont = 0;
    exp_ntx++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && busy == 0 && rd_valid == 0 && io_oe == 0 && sck == 0,
        "R8", "reset state", {cs_n, busy, rd_valid, io_oe, sck}, 6'b100000);
    rst_n = 1;
    @(negedge clk);

    do_read(24'h123456, 16'd4, 0);
    do_read(24'hABCDEF, 16'd3, 1);
    do_read(24'h000FFC, 16'd5, 1);
    do_read(24'h7FFFFE, 16'd0, 0);
    do_read(24'h400000, 16'd2, 0);

    wait_idle();
    cpol = 1;
    @(negedge clk);
    do_read(24'h0A0A0A, 16'd2, 1);
    do_read(24'hFFFFFF, 16'd2, 1);
    do_exit(0);
    do_read(24'h5A5A00, 16'd3, 0);

    do_read(24'h001234, 16'd1, 1);
    do_exit(1);
    do_read(24'h800001, 16'd2, 0);

    wait_idle();
    cpol = 0;
    @(negedge clk);
    do_read(24'h3C3C3C, 16'd6, 0);
    repeat (10) @(negedge clk);
    // R9 request while busy must be ignored
    addr = 24'h999999; len = 16'd1; req = 1;
    @(negedge clk);
    req = 0;
    wait_idle();
    repeat (4) @(negedge clk);

    // R9
    chk(ntx == exp_ntx, "R9", "transaction count", ntx, exp_ntx);
    // R6
    chk(q.size() == 0, "R6", "bytes left unreturned", q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule